// File: doc/BRIEF.md
# Ascon Permutation Round Engine

This block is the permutation core of an Ascon-based cipher or hash. It keeps a 320-bit state in a register and, once started, applies one full Ascon round on every clock cycle. A call runs either the long schedule of 12 rounds or the short schedule of 8 rounds. Every round adds a round constant, then passes the state through the 5-bit S-box layer, then through the linear diffusion layer, always in that order.

The engine has no notion of any protocol. A controller outside it loads a state in parallel, pulses start, waits for the done pulse and reads the state back in parallel. Absorbing data, padding, mixing in keys and streaming data in and out all stay with that controller. The short schedule does not have round constants of its own. It uses the final eight constants of the long schedule, so one engine serves both kinds of call.

Top module: `ascon_perm_engine`

## Requirements
- R1: While rst is high, state_o is all zeros and busy_o and done_o are low at the next clock edge, and they stay that way until reset is released.
- R2: start_i sampled high at a clock edge while busy_o is low loads state_i into the state register, and busy_o is high from that edge on. Word x0 sits in bits 319:256, x1 in 255:192, x2 in 191:128, x3 in 127:64 and x4 in 63:0. rounds_sel_i = 0 selects 12 rounds and rounds_sel_i = 1 selects 8 rounds.
- R3: The engine performs exactly one round per clock edge. busy_o stays high for exactly n cycles after the loading edge, where n is the selected round count.
- R4: done_o is high for exactly one cycle. That cycle directly follows the edge that applies the final round, and it is the cycle in which busy_o has just gone low.
- R5: Round j of an n-round call (j = 0..n-1) uses index i = 12 - n + j. It XORs the byte whose upper nibble is 15 - i and whose lower nibble is i into bits 7:0 of x2. The long schedule therefore runs from 0xF0 to 0x4B, and the short schedule runs from 0xB4 to 0x4B.
- R6: After the constant, every bit column b applies the Ascon S-box to (x0[b],x1[b],x2[b],x3[b],x4[b]). The steps are: x0^=x4, x4^=x3, x2^=x1; then each xk ^= (~x(k+1) & x(k+2)), with indices taken mod 5 and computed from the values before this step; then x1^=x0, x0^=x4, x3^=x2, x2=~x2.
- R7: After the S-box, each word is XORed with two right rotations of itself. The rotation pairs are x0 by 19 and 28, x1 by 61 and 39, x2 by 1 and 6, x3 by 10 and 17, and x4 by 7 and 41.
- R8: start_i while busy_o is high is ignored. It neither reloads the state nor changes the running schedule or its length.
- R9: While busy_o is low and no start is accepted, state_o holds its value. After done_o, the final state stays on state_o until the next accepted start.
- R10: state_o is the state register itself. After each round edge it shows the state after that round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request; takes effect only while idle |
| rounds_sel_i | input | 1 | Round count: 0 selects 12 rounds, 1 selects 8 rounds |
| state_i | input | 320 | State loaded on an accepted start (x0 in the top word) |
| busy_o | output | 1 | High while rounds are being applied |
| done_o | output | 1 | One-cycle pulse after the final round |
| state_o | output | 320 | Current state register |

## Verification
The load takes effect at the edge that accepts start, so busy_o is checked one cycle after start is raised. For an n-round call, the n round results appear at the next n edges, and done_o appears together with the last of them. The bench keeps a behavioural model that advances at each rising edge from the sampled inputs. It compares state_o, busy_o and done_o with that model at every falling edge, so each intermediate round state is checked in the cycle it becomes visible. The scenario tasks also count falling edges from start to done to confirm the exact latency, and they check that the final state holds for several idle cycles.

// File: rtl/ascon_pkg.sv
package ascon_pkg;

    localparam int WORD_W     = 64;
    localparam int NUM_WORDS  = 5;
    localparam int STATE_W    = WORD_W * NUM_WORDS;
    localparam int MAX_ROUNDS = 12;
    localparam int IDX_W      = $clog2(MAX_ROUNDS + 1);
    localparam int RC_W       = 8;

    typedef logic [WORD_W-1:0] word_t;
    // word xk lives at element [NUM_WORDS-1-k], so x0 is the top 64 bits
    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] state_t;
    typedef logic [IDX_W-1:0] rnd_idx_t;

    // rotation pairs of the diffusion layer, indexed by word number k
    localparam int ROT_A [NUM_WORDS] = '{19, 61, 1, 10, 7};
    localparam int ROT_B [NUM_WORDS] = '{28, 39, 6, 17, 41};

    function automatic int word_pos(input int k);
        return NUM_WORDS - 1 - k;
    endfunction

    function automatic word_t ror(input word_t v, input int r);
        return (v >> r) | (v << (WORD_W - r));
    endfunction

    // constant for schedule index i: upper nibble 15-i, lower nibble i
    function automatic logic [RC_W-1:0] round_const(input rnd_idx_t idx);
        logic [3:0] lo;
        lo = idx[3:0];
        return {~lo, lo};
    endfunction

    // one column of the S-box; bit 4 is x0, bit 0 is x4
    function automatic logic [4:0] sbox5(input logic [4:0] col);
        logic a0, a1, a2, a3, a4;
        logic b0, b1, b2, b3, b4;
        a0 = col[4] ^ col[0];
        a1 = col[3];
        a2 = col[2] ^ col[3];
        a3 = col[1];
        a4 = col[0] ^ col[1];
        b0 = a0 ^ (~a1 & a2);
        b1 = a1 ^ (~a2 & a3);
        b2 = a2 ^ (~a3 & a4);
        b3 = a3 ^ (~a4 & a0);
        b4 = a4 ^ (~a0 & a1);
        b1 = b1 ^ b0;
        b0 = b0 ^ b4;
        b3 = b3 ^ b2;
        b2 = ~b2;
        return {b0, b1, b2, b3, b4};
    endfunction

endpackage

// File: rtl/ascon_const_add.sv
module ascon_const_add
    import ascon_pkg::*;
(
    input  state_t   st_i,
    input  rnd_idx_t idx_i,
    output state_t   st_o
);
    localparam int X2 = 2;

    always_comb begin
        st_o = st_i;
        st_o[word_pos(X2)][RC_W-1:0] = st_i[word_pos(X2)][RC_W-1:0] ^ round_const(idx_i);
    end
endmodule

// File: rtl/ascon_sbox_layer.sv
module ascon_sbox_layer
    import ascon_pkg::*;
(
    input  state_t st_i,
    output state_t st_o
);
    for (genvar b = 0; b < WORD_W; b++) begin : g_col
        logic [4:0] col_in;
        logic [4:0] col_out;
        for (genvar k = 0; k < NUM_WORDS; k++) begin : g_pack
            assign col_in[NUM_WORDS-1-k]       = st_i[word_pos(k)][b];
            assign st_o[word_pos(k)][b]        = col_out[NUM_WORDS-1-k];
        end
        assign col_out = sbox5(col_in);
    end
endmodule

// File: rtl/ascon_linear_layer.sv
module ascon_linear_layer
    import ascon_pkg::*;
(
    input  state_t st_i,
    output state_t st_o
);
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        localparam int RA = ROT_A[k];
        localparam int RB = ROT_B[k];
        word_t w;
        assign w = st_i[word_pos(k)];
        assign st_o[word_pos(k)] = w ^ ror(w, RA) ^ ror(w, RB);
    end
endmodule

// File: rtl/ascon_round_seq.sv
module ascon_round_seq
    import ascon_pkg::*;
#(
    parameter int LONG_ROUNDS  = 12,
    parameter int SHORT_ROUNDS = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     short_i,
    output logic     busy_o,
    output logic     done_o,
    output logic     load_o,
    output logic     step_o,
    output rnd_idx_t idx_o
);
    localparam rnd_idx_t FIRST_LONG  = rnd_idx_t'(MAX_ROUNDS - LONG_ROUNDS);
    localparam rnd_idx_t FIRST_SHORT = rnd_idx_t'(MAX_ROUNDS - SHORT_ROUNDS);
    localparam rnd_idx_t LAST_IDX    = rnd_idx_t'(MAX_ROUNDS - 1);

    assign load_o = start_i && !busy_o;
    assign step_o = busy_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            idx_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (load_o) begin
                busy_o <= 1'b1;
                idx_o  <= short_i ? FIRST_SHORT : FIRST_LONG;
            end else if (busy_o) begin
                if (idx_o == LAST_IDX) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    idx_o <= idx_o + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ascon_perm_engine.sv
module ascon_perm_engine
    import ascon_pkg::*;
#(
    parameter int LONG_ROUNDS  = 12,
    parameter int SHORT_ROUNDS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               rounds_sel_i,
    input  logic [STATE_W-1:0] state_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [STATE_W-1:0] state_o
);
    state_t   st_q;
    state_t   st_rc;
    state_t   st_sb;
    state_t   st_ld;
    rnd_idx_t idx;
    logic     load;
    logic     step;

    ascon_round_seq #(
        .LONG_ROUNDS (LONG_ROUNDS),
        .SHORT_ROUNDS(SHORT_ROUNDS)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .short_i(rounds_sel_i),
        .busy_o (busy_o),
        .done_o (done_o),
        .load_o (load),
        .step_o (step),
        .idx_o  (idx)
    );

    ascon_const_add u_pc (
        .st_i (st_q),
        .idx_i(idx),
        .st_o (st_rc)
    );

    ascon_sbox_layer u_ps (
        .st_i(st_rc),
        .st_o(st_sb)
    );

    ascon_linear_layer u_pl (
        .st_i(st_sb),
        .st_o(st_ld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (load) begin
            st_q <= state_t'(state_i);
        end else if (step) begin
            st_q <= st_ld;
        end
    end

    assign state_o = st_q;
endmodule

// File: rtl/ascon_perm_engine_chk.sv
module ascon_perm_engine_chk
    import ascon_pkg::*;
#(
    parameter int LONG_ROUNDS  = 12,
    parameter int SHORT_ROUNDS = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               rounds_sel_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [STATE_W-1:0] state_o
);
    localparam int CNT_W = $clog2(MAX_ROUNDS + 2);

    logic [CNT_W-1:0] busy_cnt;
    logic [CNT_W-1:0] want_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
            want_cnt <= CNT_W'(LONG_ROUNDS);
        end else if (start_i && !busy_o) begin
            busy_cnt <= '0;
            want_cnt <= rounds_sel_i ? CNT_W'(SHORT_ROUNDS) : CNT_W'(LONG_ROUNDS);
        end else if (busy_o) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && state_o == '0));

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    assert_no_overrun_R3: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (busy_cnt < want_cnt));

    assert_round_total_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (busy_cnt == want_cnt));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(state_o));
endmodule

bind ascon_perm_engine ascon_perm_engine_chk #(
    .LONG_ROUNDS (LONG_ROUNDS),
    .SHORT_ROUNDS(SHORT_ROUNDS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .rounds_sel_i(rounds_sel_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .state_o     (state_o)
);

// File: tb/tb_ascon_perm_engine.sv
module tb_ascon_perm_engine;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         rounds_sel_i = 1'b0;
    logic [319:0] state_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [319:0] state_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    // behavioural model
    logic [319:0] m_state = '0;
    bit           m_busy = 1'b0;
    bit           m_done = 1'b0;
    int           m_left = 0;
    int           m_total = 0;

    always #10 clk = ~clk;

    ascon_perm_engine dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .rounds_sel_i(rounds_sel_i),
        .state_i     (state_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .state_o     (state_o)
    );

    function automatic logic [63:0] rotr(input logic [63:0] v, input int r);
        return (v >> r) | (v << (64 - r));
    endfunction

    function automatic logic [319:0] ref_round(input logic [319:0] s, input int i);
        logic [63:0] w [5];
        logic [63:0] o [5];
        int ra [5];
        int rb [5];
        ra = '{19, 61, 1, 10, 7};
        rb = '{28, 39, 6, 17, 41};
        for (int k = 0; k < 5; k++) w[k] = s[319 - 64*k -: 64];
        w[2] = w[2] ^ 64'((15 - i) * 16 + i);
        for (int b = 0; b < 64; b++) begin
            bit c [5];
            bit t [5];
            for (int k = 0; k < 5; k++) c[k] = w[k][b];
            c[0] ^= c[4]; c[4] ^= c[3]; c[2] ^= c[1];
            for (int k = 0; k < 5; k++) t[k] = !c[(k + 1) % 5] && c[(k + 2) % 5];
            for (int k = 0; k < 5; k++) c[k] ^= t[k];
            c[1] ^= c[0]; c[0] ^= c[4]; c[3] ^= c[2]; c[2] = !c[2];
            for (int k = 0; k < 5; k++) o[k][b] = c[k];
        end
        for (int k = 0; k < 5; k++) begin
            o[k] = o[k] ^ rotr(o[k], ra[k]) ^ rotr(o[k], rb[k]);
            s[319 - 64*k -: 64] = o[k];
        end
        return s;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_state <= '0;
            m_busy  <= 1'b0;
            m_done  <= 1'b0;
            m_left  <= 0;
        end else begin
            m_done <= 1'b0;
            if (start_i && !m_busy) begin
                m_state <= state_i;
                m_busy  <= 1'b1;
                m_total <= rounds_sel_i ? 8 : 12;
                m_left  <= rounds_sel_i ? 8 : 12;
            end else if (m_busy) begin
                m_state <= ref_round(m_state, 12 - m_left);
                m_left  <= m_left - 1;
                if (m_left == 1) begin
                    m_busy <= 1'b0;
                    m_done <= 1'b1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [319:0] act,
                         input logic [319:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            check(busy_o == m_busy, "R3 busy", 320'(busy_o), 320'(m_busy));
            check(done_o == m_done, "R4 done", 320'(done_o), 320'(m_done));
            check(state_o == m_state, "R5 R6 R7 R10 state", state_o, m_state);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [319:0] rnd320();
        logic [319:0] v;
        for (int k = 0; k < 10; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    // run one call; optionally poke start mid-run with another state
    task automatic run_call(input logic [319:0] s, input bit sel, input bit poke);
        int n;
        int waited;
        logic [319:0] fin;
        n = sel ? 8 : 12;
        @(negedge clk);
        state_i = s;
        rounds_sel_i = sel;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2 busy after start", 320'(busy_o), 320'(1));
        check(state_o == s, "R2 load", state_o, s);
        waited = 0;
        while (!done_o && waited < 20) begin
            if (poke && waited == 2) begin
                state_i = ~s;
                rounds_sel_i = !sel;
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        start_i = 1'b0;
        check(waited == n, poke ? "R8 length unchanged" : "R4 done latency",
              320'(waited), 320'(n));
        check(busy_o == 1'b0, "R4 busy low with done", 320'(busy_o), 320'(0));
        fin = state_o;
        for (int c = 0; c < 4; c++) @(negedge clk);
        check(state_o == fin, "R9 hold", state_o, fin);
        check(done_o == 1'b0, "R4 single pulse", 320'(done_o), 320'(0));
    endtask

    initial begin
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(state_o == '0, "R1 state", state_o, '0);
        check(busy_o == 1'b0 && done_o == 1'b0, "R1 flags",
              320'({busy_o, done_o}), 320'(0));
        @(negedge clk);
        rst = 1'b0;
        cmp_en = 1'b1;

        run_call('0, 1'b0, 1'b0);
        run_call('0, 1'b1, 1'b0);
        run_call({320{1'b1}}, 1'b0, 1'b0);
        run_call({5{64'h0123_4567_89AB_CDEF}}, 1'b1, 1'b0);
        run_call(320'h80, 1'b0, 1'b1);
        run_call(rnd320(), 1'b1, 1'b1);
        for (int r = 0; r < 6; r++) run_call(rnd320(), r[0], 1'b0);

        // back-to-back: new start in the cycle done is high
        @(negedge clk);
        state_i = rnd320();
        rounds_sel_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        state_i = rnd320();
        rounds_sel_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2 restart on done", 320'(busy_o), 320'(1));
        while (!done_o) @(negedge clk);
        for (int c = 0; c < 3; c++) @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule